// File: doc/BRIEF.md
# Ready-Terminated External Bus Cycle Sequencer

This block times one external memory bus cycle for a single address window. A start strobe, qualified by a read/write select, opens the cycle. The block drives the matching active-low strobe and keeps it asserted for a programmed number of wait states. It can then hold the strobe further until an external device reports, on a ready pin, that read data is valid or write data has been taken. When the cycle ends, the strobe is released and a one-clock done pulse is given.

The window's configuration consists of a ready-enable bit, a ready-polarity bit and a 4-bit cycle-time field. The meaning of the cycle-time field depends on the enable bit:

- With ready control off, all four bits form the wait count.
- With ready control on, the three low bits form the wait count. The top bit then picks how the pin is read: directly (the device meets setup and hold) or through an internal two-flop synchronizer.

Top module: `xbus_wait_seq`

## Requirements
- R1: While reset is asserted and after it is released, rd_no and wr_no are high (inactive), busy_o is 0 and done_o is 0.
- R2: With rdy_en_i = 0, a cycle keeps its strobe low for exactly cyc_time_i + 1 clocks, for all values 0 to 15 of the 4-bit field.
- R3: write_i = 0 at start selects a read cycle, which drives only rd_no low. write_i = 1 selects a write cycle, which drives only wr_no low. The two strobes are never low together.
- R4: In the clock after the cycle terminates, the strobe is high and done_o is 1 for exactly one clock. busy_o is 1 from the clock after start up to and including the done clock, and is 0 afterwards.
- R5: With rdy_en_i = 1, cyc_time_i[2:0] gives N wait states (0 to 7). The strobe stays low for at least N + 1 clocks, even when ready is already active before start.
- R6: With rdy_en_i = 1 and cyc_time_i[3] = 0 (synchronous mode), the cycle terminates at the first clock edge, at or after the end of the wait states, where the pin is at its active level. If the pin becomes active just after edge d of the cycle, the strobe is low for max(N + 1, d + 1) clocks.
- R7: With rdy_en_i = 1 and cyc_time_i[3] = 1 (asynchronous mode), the pin passes through a two-flop synchronizer. This adds exactly two clocks, so the strobe is low for max(N + 1, d + 3) clocks.
- R8: rdy_pol_i = 1 makes a high pin level active. rdy_pol_i = 0 makes a low pin level active. The inactive level extends the cycle for as long as it is held.
- R9: A start request that arrives while busy_o is 1 is ignored. It neither changes the running strobe nor opens a further cycle.
- R10: With rdy_en_i = 0, the pin level has no effect on cycle length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request to open a bus cycle, sampled while idle |
| write_i | input | 1 | 1 = write cycle, 0 = read cycle, sampled with start_i |
| rdy_en_i | input | 1 | Ready control enable for the window |
| rdy_pol_i | input | 1 | Ready active level: 1 = high, 0 = low |
| cyc_time_i | input | 4 | Cycle-time field: wait count, plus ready mode in bit 3 when ready control is enabled |
| rdy_pin_i | input | 1 | Raw ready pin from the external device |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| busy_o | output | 1 | Cycle in progress, including the done clock |
| done_o | output | 1 | One-clock pulse after termination |

## Verification
The hardest case to reach from the ports is telling apart "ready seen too early" from "ready seen at the right time". Both end the cycle, and they differ only in which clock edge the pin was first sampled at. The bench changes the pin at a falling edge a known number of clocks into the cycle, and it also presets the pin to active before start, so that the wait-state floor must win. Asynchronous cycles leave the pin inactive for several clocks before start, so that the synchronizer holds no stale active level. One run holds ready inactive for sixty clocks to show that the extension does not time out.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  // Controller phases
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_DONE = 2'd2
  } xbus_state_e;

  localparam int unsigned CT_W        = 4;          // cycle-time field width
  localparam int unsigned RDY_WAIT_W  = CT_W - 1;   // wait bits when ready enabled
  localparam int unsigned MODE_BIT    = CT_W - 1;   // ready mode select position
endpackage

// File: rtl/xbus_rdy_sync.sv
module xbus_rdy_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign chain_d[s] = d_i;
      end else begin : g_rest
        assign chain_d[s] = chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xbus_rdy_path.sv
module xbus_rdy_path #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,     // 1: high active, 0: low active
  input  logic async_i,   // 1: use synchronized path
  output logic act_o      // ready at active level, as seen by the sequencer
);
  logic pin_act;
  logic sync_act;

  // Convert to active-high before synchronizing so reset value means inactive
  assign pin_act = pol_i ? pin_i : ~pin_i;

  xbus_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_act),
    .q_o    (sync_act)
  );

  always_comb begin
    if (async_i) act_o = sync_act;
    else         act_o = pin_act;
  end
endmodule

// File: rtl/xbus_wait_cnt.sv
module xbus_wait_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i | dec_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)     cnt_d = load_val_i;
    else if (dec_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/xbus_wait_seq.sv
module xbus_wait_seq
  import xbus_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            write_i,
  input  logic            rdy_en_i,
  input  logic            rdy_pol_i,
  input  logic [CT_W-1:0] cyc_time_i,
  input  logic            rdy_pin_i,
  output logic            rd_no,
  output logic            wr_no,
  output logic            busy_o,
  output logic            done_o
);
  xbus_state_e state_q, state_d;
  logic        rd_n_q, rd_n_d;
  logic        wr_n_q, wr_n_d;
  logic        cnt_load, cnt_dec, cnt_zero;
  logic [CT_W-1:0] wait_val;
  logic        rdy_act;

  // Wait count: full field without ready control, low bits with it
  always_comb begin
    if (rdy_en_i) wait_val = {{(CT_W-RDY_WAIT_W){1'b0}}, cyc_time_i[RDY_WAIT_W-1:0]};
    else          wait_val = cyc_time_i;
  end

  xbus_wait_cnt #(.W(CT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (wait_val),
    .dec_i      (cnt_dec),
    .zero_o     (cnt_zero)
  );

  xbus_rdy_path #(.SYNC_STAGES(SYNC_STAGES)) u_rdy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (rdy_pin_i),
    .pol_i   (rdy_pol_i),
    .async_i (cyc_time_i[MODE_BIT]),
    .act_o   (rdy_act)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    rd_n_d   = rd_n_q;
    wr_n_d   = wr_n_q;
    cnt_load = 1'b0;
    cnt_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_ACT;
          cnt_load = 1'b1;
          rd_n_d   = write_i;
          wr_n_d   = ~write_i;
        end
      end
      ST_ACT: begin
        if (!cnt_zero) begin
          cnt_dec = 1'b1;
        end else if (!rdy_en_i || rdy_act) begin
          state_d = ST_DONE;
          rd_n_d  = 1'b1;
          wr_n_d  = 1'b1;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        rd_n_d  = 1'b1;
        wr_n_d  = 1'b1;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rd_n_q  <= 1'b1;
      wr_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      rd_n_q  <= rd_n_d;
      wr_n_q  <= wr_n_d;
    end
  end

  assign rd_no  = rd_n_q;
  assign wr_no  = wr_n_q;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/xbus_wait_seq_chk.sv
module xbus_wait_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic rd_no,
  input logic wr_no,
  input logic busy_o,
  input logic done_o
);
  // R1
  idle_strobes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (rd_no && wr_no));

  // R3
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no && !wr_no));

  // R4
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (rd_no && wr_no && busy_o));

  // R4
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R4
  done_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(!rd_no || !wr_no));

  // R9
  rd_open_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_no) |-> $past(!busy_o && start_i));

  // R9
  wr_open_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_no) |-> $past(!busy_o && start_i));
endmodule

bind xbus_wait_seq xbus_wait_seq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .rd_no   (rd_no),
  .wr_no   (wr_no),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/xbus_wait_seq_tb.sv
`timescale 1ns/1ps
module xbus_wait_seq_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       start_i, write_i, rdy_en_i, rdy_pol_i, rdy_pin_i;
  logic [3:0] cyc_time_i;
  logic       rd_no, wr_no, busy_o, done_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk_i = ~clk_i;

  xbus_wait_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .write_i(write_i),
    .rdy_en_i(rdy_en_i), .rdy_pol_i(rdy_pol_i), .cyc_time_i(cyc_time_i),
    .rdy_pin_i(rdy_pin_i), .rd_no(rd_no), .wr_no(wr_no),
    .busy_o(busy_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected strobe-low length from the requirements
  function automatic int exp_len(bit en, logic [3:0] ct, int d);
    int base, lat;
    if (!en) return int'(ct) + 1;                       // R2
    base = int'(ct[2:0]) + 1;                           // R5
    if (d < 0) return base;
    lat = ct[3] ? d + 3 : d + 1;                        // R7 / R6
    return (lat > base) ? lat : base;
  endfunction

  // d: -1 ready active before start, -2 never active, >=0 active after edge d
  task automatic run_cycle(input bit wr, input bit en, input bit pol,
                           input logic [3:0] ct, input int d,
                           input bit poke, input string req);
    int  len, exp;
    bit  ended;
    logic act_lvl;
    act_lvl   = pol;
    @(negedge clk_i);
    write_i   = wr;
    rdy_en_i  = en;
    rdy_pol_i = pol;
    cyc_time_i = ct;
    rdy_pin_i = (d == -1) ? act_lvl : ~act_lvl;
    repeat (4) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    len = 0; ended = 0;
    for (int k = 0; k < 200 && !ended; k++) begin
      if (k > 0) @(negedge clk_i);
      if ((wr ? wr_no : rd_no) == 1'b0) begin
        len++;
        check((wr ? rd_no : wr_no) == 1'b1, {req, " R3 other strobe"}, 0, 1);
        check(busy_o == 1'b1 && done_o == 1'b0, {req, " R4 busy in cycle"},
              {busy_o, done_o}, 2);
      end else begin
        ended = 1;
        check(done_o == 1'b1, {req, " R4 done pulse"}, done_o, 1);
        check(busy_o == 1'b1, {req, " R4 busy at done"}, busy_o, 1);
      end
      if (k == d) rdy_pin_i = act_lvl;
      if (poke && k == 1) begin start_i = 1'b1; write_i = ~wr; end
      if (poke && k == 2) begin start_i = 1'b0; write_i = wr; end
    end
    exp = exp_len(en, ct, d);
    check(len == exp, {req, " strobe length"}, len, exp);
    @(negedge clk_i);
    check(done_o == 1'b0 && busy_o == 1'b0, {req, " R4 done one clock"},
          {busy_o, done_o}, 0);
    repeat (3) begin
      @(negedge clk_i);
      check(busy_o == 1'b0 && rd_no && wr_no, {req, " R9 no extra cycle"},
            {busy_o, rd_no, wr_no}, 3);
    end
    rdy_pin_i = ~act_lvl;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; start_i = 0; write_i = 0; rdy_en_i = 0; rdy_pol_i = 0;
    rdy_pin_i = 1; cyc_time_i = 0;
    repeat (3) @(negedge clk_i);
    check(rd_no && wr_no && !busy_o && !done_o, "R1 in reset",
          {rd_no, wr_no, busy_o, done_o}, 12);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(rd_no && wr_no && !busy_o && !done_o, "R1 after reset",
          {rd_no, wr_no, busy_o, done_o}, 12);
  endtask

  task automatic t_no_ready();
    run_cycle(0, 0, 1, 4'd0,  -2, 0, "R2 ct0 read");
    run_cycle(1, 0, 1, 4'd7,  -2, 0, "R2 ct7 write");
    run_cycle(0, 0, 0, 4'd15, -2, 0, "R2 ct15 read");
    run_cycle(1, 0, 1, 4'd9,  -2, 0, "R10 pin inactive");
    run_cycle(0, 0, 1, 4'd3,  -1, 0, "R10 pin active");
  endtask

  task automatic t_wait_floor();
    run_cycle(0, 1, 1, 4'b0000, -1, 0, "R5 sync n0 preactive");
    run_cycle(1, 1, 0, 4'b0111, -1, 0, "R5 sync n7 preactive");
    run_cycle(0, 1, 1, 4'b1111, -1, 0, "R5 async n7 preactive");
    run_cycle(1, 1, 1, 4'b1010, -1, 0, "R5 async n2 preactive");
  endtask

  task automatic t_sync();
    run_cycle(0, 1, 1, 4'b0001, 3, 0, "R6 sync d3");
    run_cycle(1, 1, 1, 4'b0000, 0, 0, "R6 sync d0");
    run_cycle(0, 1, 0, 4'b0010, 5, 0, "R8 low active sync");
    run_cycle(1, 1, 1, 4'b0010, 5, 0, "R8 high active sync");
  endtask

  task automatic t_async();
    run_cycle(0, 1, 1, 4'b1001, 3, 0, "R7 async d3");
    run_cycle(1, 1, 0, 4'b1000, 0, 0, "R7 async d0 low active");
    run_cycle(0, 1, 0, 4'b1011, 60, 0, "R8 async long inactive");
    run_cycle(1, 1, 1, 4'b0011, 40, 0, "R8 sync long inactive");
  endtask

  task automatic t_busy_start();
    run_cycle(0, 0, 1, 4'd5, -2, 1, "R9 start while busy read");
    run_cycle(1, 1, 1, 4'b0001, 4, 1, "R9 start while busy write");
  endtask

  initial begin
    t_reset();
    t_no_ready();
    t_wait_floor();
    t_sync();
    t_async();
    t_busy_start();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule